// File: doc/BRIEF.md
# Multi-class physical register free list

This block holds the unallocated physical register tags for a register-renaming stage. It keeps three pools: integer, floating-point and condition-code. Each pool is a circular queue, so the tag that has been free the longest is the next one granted. Each class has its own allocate request. The grant and its tag appear combinationally in the cycle of the request, and the pool advances at the next clock edge.

All tags share one index space. Integer tags come first, floating-point tags follow the last integer tag, and condition-code tags follow the last floating-point tag. A single release port carries a tag and a two-bit class field, and the accepted tag goes to the pool that the class field selects. The block rejects releases that cannot be correct. A class code outside the three legal ones is refused. So is a tag outside the range of its class, and so is a tag that is already free. A rejected release changes no pool.

At reset the lowest tags of each class are held back for the initial architectural mappings. The remaining tags of each class are loaded into its pool in ascending order.

Top module: `phys_tag_pool`

## Requirements
- R1: After reset each pool holds its class size minus its reserved count. With the default parameters the counts are 12 integer, 12 floating-point and 6 condition-code. The first tags granted are 4, 20 and 34.
- R2: Within a class, tags are granted in first-in first-out order. Reset contents come out in ascending order, and released tags come out in the order they were released.
- R3: A request to an empty pool raises that class's bit of `alloc_err`, leaves its `alloc_vld` bit low and its tag field zero, and does not change the count.
- R4: An accepted release goes to the pool chosen by `rel_cls`: 0 is integer, 1 is floating-point, 2 is condition-code. That pool's count rises by one at the next edge.
- R5: A release with `rel_cls` equal to 3, or with a tag outside the range of its class, raises `rel_err_cls` in that cycle. No pool is updated.
- R6: `free_cnt` gives each pool's current number of free tags. Integer is in bits [4:0], floating-point in [9:5] and condition-code in [14:10]. Each `not_empty` bit is high exactly when its count is nonzero.
- R7: The index space is shared. Integer tags are 0 to 15, floating-point tags 16 to 31 and condition-code tags 32 to 39. Grants carry these absolute tags, and the integer, floating-point and condition-code tag fields are bits [5:0], [11:6] and [17:12] of `alloc_tag`.
- R8: Releasing a tag that is already free raises `rel_err_dbl`. The tag is dropped, so no count ever exceeds its class size.
- R9: A grant and an accepted release to the same pool in one cycle leave that pool's count unchanged.
- R10: When a pool is empty and a request and an accepted release reach it in the same cycle, the request is refused that cycle. The released tag is stored and is granted by the next request.
- R11: Each grant takes effect at the next edge. A request held for two cycles receives two different consecutive tags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_req | input | 3 | Per-class allocate request (bit 0 integer, 1 floating-point, 2 condition-code) |
| alloc_vld | output | 3 | Per-class grant |
| alloc_tag | output | 18 | Granted tags, 6 bits per class, zero when not granted |
| alloc_err | output | 3 | Per-class request to an empty pool |
| rel_vld | input | 1 | Release strobe |
| rel_cls | input | 2 | Class of the released tag |
| rel_tag | input | 6 | Released tag |
| rel_err_cls | output | 1 | Release refused: illegal class or tag outside its class range |
| rel_err_dbl | output | 1 | Release refused: tag already free |
| free_cnt | output | 15 | Per-class free counts, 5 bits each |
| not_empty | output | 3 | Per-class pool holds at least one tag |

## Verification
The hardest case to reach is R10. It needs an empty pool, a request to that pool and a legal release of a tag that is not already free, all in one cycle. The stimulus first drains the condition-code pool with back-to-back requests until `alloc_err` appears. It then releases tag 33 in the same cycle as a request. Tag 33 was reserved at reset and so was never free. A final request confirms that the stored tag comes out next. The double-release case is reached by returning tags that reset left free, and by returning a tag in the very cycle it is being granted.

// File: rtl/phys_tag_pool.sv
module phys_tag_pool #(
  parameter int INT_REGS = 16,
  parameter int FP_REGS  = 16,
  parameter int CC_REGS  = 8,
  parameter int INT_RSV  = 4,
  parameter int FP_RSV   = 4,
  parameter int CC_RSV   = 2,
  localparam int TOTAL   = INT_REGS + FP_REGS + CC_REGS,
  localparam int TAG_W   = $clog2(TOTAL),
  localparam int MAXN    = (INT_REGS > FP_REGS) ? ((INT_REGS > CC_REGS) ? INT_REGS : CC_REGS)
                                                : ((FP_REGS > CC_REGS) ? FP_REGS : CC_REGS),
  localparam int CNT_W   = $clog2(MAXN + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [2:0]         alloc_req,
  output logic [2:0]         alloc_vld,
  output logic [3*TAG_W-1:0] alloc_tag,
  output logic [2:0]         alloc_err,
  input  logic               rel_vld,
  input  logic [1:0]         rel_cls,
  input  logic [TAG_W-1:0]   rel_tag,
  output logic               rel_err_cls,
  output logic               rel_err_dbl,
  output logic [3*CNT_W-1:0] free_cnt,
  output logic [2:0]         not_empty
);

  localparam int FP_BASE = INT_REGS;
  localparam int CC_BASE = INT_REGS + FP_REGS;

  logic [TOTAL-1:0] free_q;
  logic [2:0]       pop;
  logic [TAG_W-1:0] head [3];
  logic             in_rng, rel_ok;

  always_comb begin
    case (rel_cls)
      2'd0:    in_rng = rel_tag < TAG_W'(FP_BASE);
      2'd1:    in_rng = rel_tag >= TAG_W'(FP_BASE) && rel_tag < TAG_W'(CC_BASE);
      2'd2:    in_rng = rel_tag >= TAG_W'(CC_BASE) && {1'b0, rel_tag} < (TAG_W+1)'(TOTAL);
      default: in_rng = 1'b0;
    endcase
  end

  assign rel_err_cls = rel_vld && !in_rng;
  assign rel_err_dbl = rel_vld && in_rng && free_q[rel_tag];
  assign rel_ok      = rel_vld && in_rng && !free_q[rel_tag];

  function automatic logic init_free(int i);
    if (i < FP_BASE)      return i >= INT_RSV;
    else if (i < CC_BASE) return i >= FP_BASE + FP_RSV;
    else                  return i >= CC_BASE + CC_RSV;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < TOTAL; i++) free_q[i] <= init_free(i);
    end else begin
      for (int c = 0; c < 3; c++)
        if (pop[c]) free_q[head[c]] <= 1'b0;
      if (rel_ok) free_q[rel_tag] <= 1'b1;
    end
  end

  for (genvar c = 0; c < 3; c++) begin : g_pool
    localparam int N    = (c == 0) ? INT_REGS : (c == 1) ? FP_REGS : CC_REGS;
    localparam int RSV  = (c == 0) ? INT_RSV  : (c == 1) ? FP_RSV  : CC_RSV;
    localparam int BASE = (c == 0) ? 0        : (c == 1) ? FP_BASE : CC_BASE;
    localparam int PW   = (N > 1) ? $clog2(N) : 1;

    logic [TAG_W-1:0] mem [N];
    logic [PW-1:0]    rd, wr;
    logic [CNT_W-1:0] cnt;
    logic             push;

    assign push     = rel_ok && rel_cls == 2'(c);
    assign pop[c]   = alloc_req[c] && cnt != '0;
    assign head[c]  = mem[rd];

    assign alloc_vld[c] = pop[c];
    assign alloc_err[c] = alloc_req[c] && cnt == '0;
    assign alloc_tag[c*TAG_W +: TAG_W] = pop[c] ? head[c] : '0;
    assign free_cnt[c*CNT_W +: CNT_W]  = cnt;
    assign not_empty[c] = cnt != '0;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rd  <= '0;
        wr  <= PW'((N - RSV) % N);
        cnt <= CNT_W'(N - RSV);
        for (int i = 0; i < N; i++)
          mem[i] <= (i < N - RSV) ? TAG_W'(BASE + RSV + i) : '0;
      end else begin
        if (push) begin
          mem[wr] <= rel_tag;
          wr <= (wr == PW'(N - 1)) ? '0 : wr + 1'b1;
        end
        if (pop[c]) rd <= (rd == PW'(N - 1)) ? '0 : rd + 1'b1;
        cnt <= cnt + CNT_W'(push) - CNT_W'(pop[c]);
      end
    end
  end

endmodule

// File: rtl/pool_chk.sv
module pool_chk #(
  parameter int CNT_W    = 5,
  parameter int INT_REGS = 16,
  parameter int FP_REGS  = 16,
  parameter int CC_REGS  = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic [2:0]         alloc_req,
  input logic [2:0]         alloc_vld,
  input logic [2:0]         alloc_err,
  input logic               rel_vld,
  input logic [1:0]         rel_cls,
  input logic               rel_err_cls,
  input logic               rel_err_dbl,
  input logic [3*CNT_W-1:0] free_cnt,
  input logic [2:0]         not_empty
);

  AST_ERR_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_err & alloc_vld) == 3'b000); // R3

  AST_GRANT_WHEN_AVAIL: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_req & not_empty) == alloc_vld); // R6

  AST_CLS_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    rel_err_cls && alloc_req == 3'b000 |=> $stable(free_cnt)); // R5

  AST_DBL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    rel_err_dbl && alloc_req == 3'b000 |=> $stable(free_cnt)); // R8

  AST_INT_BALANCE: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_vld[0] && rel_vld && rel_cls == 2'd0 && !rel_err_cls && !rel_err_dbl
    |=> $stable(free_cnt[CNT_W-1:0])); // R9

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    free_cnt[CNT_W-1:0] <= CNT_W'(INT_REGS) && free_cnt[2*CNT_W-1:CNT_W] <= CNT_W'(FP_REGS)
    && free_cnt[3*CNT_W-1:2*CNT_W] <= CNT_W'(CC_REGS)); // R8

endmodule

bind phys_tag_pool pool_chk #(
  .CNT_W(CNT_W), .INT_REGS(INT_REGS), .FP_REGS(FP_REGS), .CC_REGS(CC_REGS)
) u_pool_chk (
  .clk(clk), .rst_n(rst_n), .alloc_req(alloc_req), .alloc_vld(alloc_vld),
  .alloc_err(alloc_err), .rel_vld(rel_vld), .rel_cls(rel_cls),
  .rel_err_cls(rel_err_cls), .rel_err_dbl(rel_err_dbl),
  .free_cnt(free_cnt), .not_empty(not_empty)
);

// File: tb/test_phys_tag_pool.sv
module test_phys_tag_pool;
  localparam int NI = 16, NF = 16, NC = 8, RI = 4, RF = 4, RC = 2;
  localparam int TOT = NI + NF + NC;
  localparam int TW = 6, CW = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] alloc_req = '0, alloc_vld, alloc_err, not_empty;
  logic [3*TW-1:0] alloc_tag;
  logic rel_vld = 1'b0, rel_err_cls, rel_err_dbl;
  logic [1:0] rel_cls = '0;
  logic [TW-1:0] rel_tag = '0;
  logic [3*CW-1:0] free_cnt;

  always #2 clk = ~clk;

  phys_tag_pool i_phys_tag_pool (
    .clk(clk), .rst_n(rst_n), .alloc_req(alloc_req), .alloc_vld(alloc_vld),
    .alloc_tag(alloc_tag), .alloc_err(alloc_err), .rel_vld(rel_vld),
    .rel_cls(rel_cls), .rel_tag(rel_tag), .rel_err_cls(rel_err_cls),
    .rel_err_dbl(rel_err_dbl), .free_cnt(free_cnt), .not_empty(not_empty)
  );

  typedef struct {
    string      req;
    logic [2:0] vld, err, ne;
    int         tag [3];
    int         cnt [3];
    logic       ecls, edbl;
  } exp_t;

  exp_t exp_q[$];
  int   pool [3][$];
  bit   fr [TOT];
  int   n_chk = 0, n_fail = 0;
  bit   done = 1'b0;
  event drv_ev;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit in_range(int c, int t);
    case (c)
      0: return t < NI;
      1: return t >= NI && t < NI + NF;
      2: return t >= NI + NF && t < TOT;
      default: return 0;
    endcase
  endfunction

  task automatic step(string req, logic [2:0] rq, bit rv = 0, int rc = 0, int rt = 0);
    exp_t e;
    bit ok;
    @(negedge clk);
    alloc_req = rq; rel_vld = rv; rel_cls = 2'(rc); rel_tag = TW'(rt);
    e.req = req;
    for (int c = 0; c < 3; c++) begin
      e.cnt[c] = pool[c].size();
      e.ne[c]  = pool[c].size() > 0;
      e.vld[c] = rq[c] && pool[c].size() > 0;
      e.err[c] = rq[c] && pool[c].size() == 0;
      e.tag[c] = e.vld[c] ? pool[c][0] : 0;
    end
    e.ecls = rv && !in_range(rc, rt);
    e.edbl = rv && in_range(rc, rt) && fr[rt];
    ok = rv && in_range(rc, rt) && !fr[rt];
    exp_q.push_back(e);
    -> drv_ev;
    for (int c = 0; c < 3; c++)
      if (e.vld[c]) begin
        fr[pool[c][0]] = 0;
        void'(pool[c].pop_front());
      end
    if (ok) begin
      pool[rc].push_back(rt);
      fr[rt] = 1;
    end
    @(posedge clk);
  endtask

  initial begin
    forever begin
      @(drv_ev);
      #1;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        chk(alloc_vld === e.vld, e.req, "alloc_vld", alloc_vld, e.vld);
        chk(alloc_err === e.err, e.req, "alloc_err", alloc_err, e.err);
        chk(not_empty === e.ne, e.req, "not_empty", not_empty, e.ne);
        chk(rel_err_cls === e.ecls, e.req, "rel_err_cls", rel_err_cls, e.ecls);
        chk(rel_err_dbl === e.edbl, e.req, "rel_err_dbl", rel_err_dbl, e.edbl);
        for (int c = 0; c < 3; c++) begin
          chk(free_cnt[c*CW +: CW] === CW'(e.cnt[c]), e.req, $sformatf("free_cnt[%0d]", c),
              int'(free_cnt[c*CW +: CW]), e.cnt[c]);
          chk(alloc_tag[c*TW +: TW] === TW'(e.tag[c]), e.req, $sformatf("alloc_tag[%0d]", c),
              int'(alloc_tag[c*TW +: TW]), e.tag[c]);
        end
      end
    end
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < TOT; i++) fr[i] = 0;
    for (int i = RI; i < NI; i++) begin pool[0].push_back(i); fr[i] = 1; end
    for (int i = NI + RF; i < NI + NF; i++) begin pool[1].push_back(i); fr[i] = 1; end
    for (int i = NI + NF + RC; i < TOT; i++) begin pool[2].push_back(i); fr[i] = 1; end
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    step("R1", 3'b000);
    step("R7", 3'b111);
    step("R2", 3'b001);
    step("R11", 3'b001);
    step("R11", 3'b001);
    step("R4", 3'b000, 1, 0, 4);
    step("R4", 3'b000, 1, 1, 20);
    step("R4", 3'b000, 1, 2, 34);
    step("R6", 3'b000, 1, 0, 5);
    step("R5", 3'b000, 1, 3, 10);
    step("R5", 3'b000, 1, 1, 3);
    step("R5", 3'b000, 1, 0, 36);
    step("R8", 3'b000, 1, 0, 10);
    step("R8", 3'b000, 1, 1, 25);
    step("R8", 3'b001, 1, 0, 8);
    step("R9", 3'b001, 1, 0, 0);
    step("R9", 3'b010, 1, 1, 17);
    for (int i = 0; i < 10; i++) step("R3", 3'b100);
    step("R6", 3'b000);
    step("R10", 3'b100, 1, 2, 33);
    step("R10", 3'b100);
    step("R3", 3'b100);
    for (int i = 0; i < 14; i++) step("R2", 3'b001);
    step("R6", 3'b000);
    step("R2", 3'b010);

    @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule